// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block steps through a table of 8-byte region descriptors kept in memory. For each region it produces a run of 16-bit word transfer requests for one DMA channel. Software sets a table base pointer and a direction bit, then raises a start control. On the rising edge of that control the walker reads the first descriptor as two 32-bit reads. It loads a region address and a byte count, then issues one memory request per word until the region is used up. After that it fetches the next descriptor, which sits 8 bytes further on.

The walker stops in three cases. It stops after the last word of a descriptor whose last-entry flag is set. It stops when software drops the start control, and all walker state is then discarded. It stops when any memory response reports an error, and then it raises a one-cycle error pulse. The memory port stands in for the host bus. The request side is valid/ready: once the walker raises `mreq_valid_o`, it holds the address and write flag unchanged until a cycle with `mreq_ready_i` high accepts the request. Only one request is ever outstanding. The response side has no back-pressure, because the walker accepts the single `mrsp_valid_i` beat whenever it comes. The disk side shows up only as `xfer_avail_i`, which says whether a word may move now.

Top module: `sg_walker`

## Requirements
- R1: A zero-to-one change of `start_i` makes `active_o` high on the next cycle. The first request is then a read at the table base with bits [1:0] cleared, and the second is a read at that address plus 4.
- R2: Holding `start_i` high with no new rising edge starts nothing. After a walk ends, `active_o` stays low and no request is issued.
- R3: The first descriptor dword gives the region byte address with bit 0 forced to 0. In the second dword, bits [15:0] give the byte count with bit 0 ignored, and bit 31 is the last-entry flag.
- R4: A count field of zero means 65536 bytes, which is 32768 word transfers.
- R5: Each word request moves the region address up by 2. Only address bits [15:0] count, so bits [31:16] keep their loaded value.
- R6: The next descriptor is read at the previous descriptor address plus 8. Only the low 16 bits of that address count.
- R7: Word requests carry `mreq_write_o` equal to the `dir_i` value captured at the start edge (0 = memory read, 1 = memory write). Descriptor fetches always have `mreq_write_o` = 0.
- R8: After the response to the last word of a descriptor whose last-entry flag is set, `active_o` goes low and no further request is issued.
- R9: While `start_i` is low, the walker returns to idle with `active_o` low on the next cycle and issues no requests. A later start edge begins again at the table base.
- R10: A response with `mrsp_err_i` high stops the walk. `active_o` goes low, `err_o` is high for exactly one cycle, and no further request is issued. `err_o` is never high without such a response.
- R11: While `xfer_avail_i` is low, no word request is raised and `active_o` stays high.
- R12: A request held with `mreq_ready_i` low keeps `mreq_valid_o`, `mreq_addr_o` and `mreq_write_o` unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start control; its rising edge begins a walk, and a low level stops it |
| dir_i | input | 1 | Transfer direction, 0 = memory read, 1 = memory write |
| tbl_base_i | input | 32 | Descriptor table base address |
| xfer_avail_i | input | 1 | Disk side ready to move a word |
| mreq_valid_o | output | 1 | Memory request valid |
| mreq_ready_i | input | 1 | Memory request accepted |
| mreq_addr_o | output | 32 | Memory request byte address |
| mreq_write_o | output | 1 | Memory request is a write |
| mrsp_valid_i | input | 1 | Memory response valid |
| mrsp_data_i | input | 32 | Memory read data |
| mrsp_err_i | input | 1 | Memory response carries an error |
| active_o | output | 1 | Walk in progress |
| err_o | output | 1 | One-cycle pulse after an error response |

## Verification
The assertions check on every cycle that a stalled request holds its address and write flag, and that a low start control empties the walker on the next cycle. They also check that the error pulse lasts one cycle, comes only from an error response and is never seen while active, and that requests appear only while active and always word aligned. Only the bench scenarios can show the order of addresses. That covers the 64 KiB wrap of both the region address and the descriptor pointer, the full-size zero-count region, the direction captured at start, the restart from the first entry after a stop, and the pause while the disk side has no data.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_D0_REQ,
    ST_D0_WAIT,
    ST_D1_REQ,
    ST_D1_WAIT,
    ST_W_HOLD,
    ST_W_REQ,
    ST_W_WAIT
  } walk_state_t;

  // last-entry flag position in the second descriptor dword
  localparam int unsigned EOT_BIT    = 31;
  localparam int unsigned DESC_BYTES = 8;
  localparam int unsigned DW_BYTES   = 4;
endpackage

// File: rtl/sg_start_edge.sv
module sg_start_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic rise_o
);
  logic start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_i;
  end

  assign rise_o = start_i && !start_q;
endmodule

// File: rtl/sg_region.sv
module sg_region import sg_pkg::*; #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned SEG_W      = 16,
  parameter int unsigned WORD_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic              dir_i,
  input  logic              ld_addr_i,
  input  logic              ld_cnt_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] data_i,
  output logic [ADDR_W-1:0] desc0_addr_o,
  output logic [ADDR_W-1:0] desc1_addr_o,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic              last_word_o,
  output logic              eot_o,
  output logic              dir_o
);
  localparam int unsigned CNT_W = SEG_W + 1;
  localparam int unsigned HI_W  = ADDR_W - SEG_W;
  localparam logic [SEG_W-1:0] WORD_MASK = ~SEG_W'(WORD_BYTES - 1);
  localparam logic [SEG_W-1:0] DW_MASK   = ~SEG_W'(DW_BYTES - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = {1'b1, {SEG_W{1'b0}}};

  logic [HI_W-1:0]  tbl_hi;
  logic [SEG_W-1:0] dptr_lo;
  logic [HI_W-1:0]  reg_hi;
  logic [SEG_W-1:0] reg_lo;
  logic [CNT_W-1:0] rcnt;
  logic             eot_q;
  logic             dir_q;
  logic [SEG_W-1:0] cnt_field;

  assign cnt_field = data_i[SEG_W-1:0] & WORD_MASK;

  // descriptor pointer: high part fixed, low part wraps inside its window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_hi  <= '0;
      dptr_lo <= '0;
      dir_q   <= 1'b0;
    end else if (arm_i) begin
      tbl_hi  <= tbl_base_i[ADDR_W-1:SEG_W];
      dptr_lo <= tbl_base_i[SEG_W-1:0] & DW_MASK;
      dir_q   <= dir_i;
    end else if (ld_cnt_i) begin
      dptr_lo <= dptr_lo + SEG_W'(DESC_BYTES);
    end
  end

  // region address and remaining byte count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_hi <= '0;
      reg_lo <= '0;
      rcnt   <= '0;
      eot_q  <= 1'b0;
    end else begin
      if (ld_addr_i) begin
        reg_hi <= data_i[ADDR_W-1:SEG_W];
        reg_lo <= data_i[SEG_W-1:0] & WORD_MASK;
      end else if (step_i) begin
        reg_lo <= reg_lo + SEG_W'(WORD_BYTES);
      end
      if (ld_cnt_i) begin
        rcnt  <= (cnt_field == '0) ? FULL_CNT : {1'b0, cnt_field};
        eot_q <= data_i[EOT_BIT];
      end else if (step_i) begin
        rcnt <= rcnt - CNT_W'(WORD_BYTES);
      end
    end
  end

  assign desc0_addr_o = {tbl_hi, dptr_lo};
  assign desc1_addr_o = {tbl_hi, dptr_lo + SEG_W'(DW_BYTES)};
  assign word_addr_o  = {reg_hi, reg_lo};
  assign last_word_o  = (rcnt == CNT_W'(WORD_BYTES));
  assign eot_o        = eot_q;
  assign dir_o        = dir_q;
endmodule

// File: rtl/sg_seq.sv
module sg_seq import sg_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        rise_i,
  input  logic        avail_i,
  input  logic        req_ready_i,
  input  logic        rsp_valid_i,
  input  logic        rsp_err_i,
  input  logic        last_word_i,
  input  logic        eot_i,
  output walk_state_t state_o,
  output logic        arm_o,
  output logic        ld_addr_o,
  output logic        ld_cnt_o,
  output logic        step_o,
  output logic        err_o
);
  walk_state_t state, nxt;
  logic waiting, rsp_ok, rsp_bad, err_set;

  assign waiting = (state == ST_D0_WAIT) || (state == ST_D1_WAIT) || (state == ST_W_WAIT);
  assign rsp_ok  = rsp_valid_i && !rsp_err_i;
  assign rsp_bad = rsp_valid_i && rsp_err_i;

  always_comb begin
    nxt       = state;
    arm_o     = 1'b0;
    ld_addr_o = 1'b0;
    ld_cnt_o  = 1'b0;
    step_o    = 1'b0;
    err_set   = 1'b0;
    if (!start_i) begin
      nxt = ST_IDLE;
    end else if (waiting && rsp_bad) begin
      nxt     = ST_IDLE;
      err_set = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: if (rise_i) begin
          nxt   = ST_D0_REQ;
          arm_o = 1'b1;
        end
        ST_D0_REQ:  if (req_ready_i) nxt = ST_D0_WAIT;
        ST_D0_WAIT: if (rsp_ok) begin
          ld_addr_o = 1'b1;
          nxt       = ST_D1_REQ;
        end
        ST_D1_REQ:  if (req_ready_i) nxt = ST_D1_WAIT;
        ST_D1_WAIT: if (rsp_ok) begin
          ld_cnt_o = 1'b1;
          nxt      = avail_i ? ST_W_REQ : ST_W_HOLD;
        end
        ST_W_HOLD:  if (avail_i) nxt = ST_W_REQ;
        ST_W_REQ:   if (req_ready_i) nxt = ST_W_WAIT;
        ST_W_WAIT:  if (rsp_ok) begin
          step_o = 1'b1;
          if (last_word_i) nxt = eot_i ? ST_IDLE : ST_D0_REQ;
          else             nxt = avail_i ? ST_W_REQ : ST_W_HOLD;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      err_o <= 1'b0;
    end else begin
      state <= nxt;
      err_o <= err_set;
    end
  end

  assign state_o = state;
endmodule

// File: rtl/sg_walker.sv
module sg_walker import sg_pkg::*; #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned SEG_W      = 16,
  parameter int unsigned WORD_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              dir_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic              xfer_avail_i,
  output logic              mreq_valid_o,
  input  logic              mreq_ready_i,
  output logic [ADDR_W-1:0] mreq_addr_o,
  output logic              mreq_write_o,
  input  logic              mrsp_valid_i,
  input  logic [ADDR_W-1:0] mrsp_data_i,
  input  logic              mrsp_err_i,
  output logic              active_o,
  output logic              err_o
);
  walk_state_t       state;
  logic              rise, arm, ld_addr, ld_cnt, step;
  logic              last_word, eot, dir_q;
  logic [ADDR_W-1:0] desc0_addr, desc1_addr, word_addr;

  sg_start_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .rise_o  (rise)
  );

  sg_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .rise_i      (rise),
    .avail_i     (xfer_avail_i),
    .req_ready_i (mreq_ready_i),
    .rsp_valid_i (mrsp_valid_i),
    .rsp_err_i   (mrsp_err_i),
    .last_word_i (last_word),
    .eot_i       (eot),
    .state_o     (state),
    .arm_o       (arm),
    .ld_addr_o   (ld_addr),
    .ld_cnt_o    (ld_cnt),
    .step_o      (step),
    .err_o       (err_o)
  );

  sg_region #(
    .ADDR_W     (ADDR_W),
    .SEG_W      (SEG_W),
    .WORD_BYTES (WORD_BYTES)
  ) u_region (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm_i        (arm),
    .tbl_base_i   (tbl_base_i),
    .dir_i        (dir_i),
    .ld_addr_i    (ld_addr),
    .ld_cnt_i     (ld_cnt),
    .step_i       (step),
    .data_i       (mrsp_data_i),
    .desc0_addr_o (desc0_addr),
    .desc1_addr_o (desc1_addr),
    .word_addr_o  (word_addr),
    .last_word_o  (last_word),
    .eot_o        (eot),
    .dir_o        (dir_q)
  );

  always_comb begin
    mreq_valid_o = 1'b0;
    mreq_write_o = 1'b0;
    mreq_addr_o  = word_addr;
    unique case (state)
      ST_D0_REQ: begin
        mreq_valid_o = 1'b1;
        mreq_addr_o  = desc0_addr;
      end
      ST_D1_REQ: begin
        mreq_valid_o = 1'b1;
        mreq_addr_o  = desc1_addr;
      end
      ST_W_REQ: begin
        mreq_valid_o = 1'b1;
        mreq_write_o = dir_q;
      end
      default: ;
    endcase
  end

  assign active_o = (state != ST_IDLE);
endmodule

// File: rtl/sg_walker_chk.sv
module sg_walker_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              mreq_valid_o,
  input logic              mreq_ready_i,
  input logic [ADDR_W-1:0] mreq_addr_o,
  input logic              mreq_write_o,
  input logic              mrsp_valid_i,
  input logic              mrsp_err_i,
  input logic              active_o,
  input logic              err_o
);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid_o && !mreq_ready_i && start_i) |=>
      (mreq_valid_o && $stable(mreq_addr_o) && $stable(mreq_write_o)));

  assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !active_o);

  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  assert_err_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !active_o);

  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(mrsp_valid_i && mrsp_err_i));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> !mreq_valid_o);

  assert_word_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid_o |-> !mreq_addr_o[0]);

  assert_start_needed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> $past(start_i));
endmodule

bind sg_walker sg_walker_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_sg_walker.sv
module test_sg_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        dir_i = 1'b0;
  logic [31:0] tbl_base_i = '0;
  logic        xfer_avail_i = 1'b1;
  logic        mreq_valid_o;
  logic        mreq_ready_i = 1'b1;
  logic [31:0] mreq_addr_o;
  logic        mreq_write_o;
  logic        mrsp_valid_i = 1'b0;
  logic [31:0] mrsp_data_i = '0;
  logic        mrsp_err_i = 1'b0;
  logic        active_o;
  logic        err_o;

  always #5 clk = ~clk;

  sg_walker i_sg_walker (.*);

  int n_chk = 0;
  int n_fail = 0;
  int err_cnt = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] log_addr [$];
  logic        log_wr [$];
  logic [31:0] exp_addr [$];
  logic        exp_wr [$];
  logic        stall = 1'b0;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory responder: one request outstanding, response one cycle after accept
  initial begin : responder
    logic        pend = 1'b0;
    logic [31:0] pend_a = '0;
    forever begin
      @(negedge clk);
      mrsp_valid_i = 1'b0;
      mrsp_err_i   = 1'b0;
      if (err_o) err_cnt++;
      if (pend) begin
        mrsp_valid_i = 1'b1;
        mrsp_data_i  = rd(pend_a);
        mrsp_err_i   = err_en && (pend_a == err_addr);
        pend = 1'b0;
      end
      mreq_ready_i = stall ? ~mreq_ready_i : 1'b1;
      if (rst_n && mreq_valid_o && mreq_ready_i) begin
        log_addr.push_back(mreq_addr_o);
        log_wr.push_back(mreq_write_o);
        pend   = 1'b1;
        pend_a = mreq_addr_o;
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic put_desc(logic [31:0] at, logic [31:0] base, logic [15:0] cnt, logic last);
    mem[at] = base;
    mem[{at[31:16], at[15:0] + 16'd4}] = {last, 15'b0, cnt};
  endtask

  task automatic exp_fetch(logic [31:0] at);
    exp_addr.push_back(at);                          exp_wr.push_back(1'b0);
    exp_addr.push_back({at[31:16], at[15:0] + 16'd4}); exp_wr.push_back(1'b0);
  endtask

  task automatic exp_words(logic [31:0] base, int n, logic wr);
    for (int k = 0; k < n; k++) begin
      exp_addr.push_back({base[31:16], base[15:0] + 16'(2 * k)});
      exp_wr.push_back(wr);
    end
  endtask

  task automatic check_seq(string tag);
    int bad = -1;
    check({tag, " count"}, 32'(log_addr.size()), 32'(exp_addr.size()));
    for (int k = 0; k < exp_addr.size() && k < log_addr.size(); k++)
      if (bad < 0 && (log_addr[k] !== exp_addr[k] || log_wr[k] !== exp_wr[k])) bad = k;
    n_chk++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s entry %0d: actual=0x%08h/w%0b expected=0x%08h/w%0b", tag, bad,
               log_addr[bad], log_wr[bad], exp_addr[bad], exp_wr[bad]);
    end
  endtask

  task automatic clear_logs();
    log_addr.delete(); log_wr.delete();
    exp_addr.delete(); exp_wr.delete();
  endtask

  task automatic wait_idle(string tag, int max);
    int k = 0;
    while (active_o && k < max) begin
      @(negedge clk);
      k++;
    end
    check({tag, " walk ends"}, 32'(active_o), 32'h0);
  endtask

  task automatic go(logic [31:0] base, logic dir);
    @(negedge clk);
    tbl_base_i = base;
    dir_i      = dir;
    start_i    = 1'b1;
  endtask

  task automatic halt();
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    clear_logs();
  endtask

  task automatic t_reset();
    check("reset active_o", 32'(active_o), 32'h0);
    check("reset mreq_valid_o", 32'(mreq_valid_o), 32'h0);
    check("reset err_o", 32'(err_o), 32'h0);
  endtask

  // R1 R3 R7 R8: two descriptors, read direction, odd bits ignored
  task automatic t_basic();
    put_desc(32'h0000_1000, 32'h0008_0101, 16'h0007, 1'b0);
    put_desc(32'h0000_1008, 32'h0009_0000, 16'h0004, 1'b1);
    clear_logs();
    err_cnt = 0;
    go(32'h0000_1003, 1'b0);
    @(negedge clk);
    check("R1 active next cycle", 32'(active_o), 32'h1);
    check("R1 first fetch addr", mreq_addr_o, 32'h0000_1000);
    wait_idle("R8 basic", 200);
    exp_fetch(32'h0000_1000);
    exp_words(32'h0008_0100, 3, 1'b0);
    exp_fetch(32'h0000_1008);
    exp_words(32'h0009_0000, 2, 1'b0);
    check_seq("R3 R7 basic sequence");
    check("R10 no spurious err_o", 32'(err_cnt), 32'h0);
  endtask

  // R2: start held high after completion does nothing
  task automatic t_no_level();
    clear_logs();
    repeat (20) @(negedge clk);
    check("R2 stays idle", 32'(active_o), 32'h0);
    check("R2 no requests", 32'(log_addr.size()), 32'h0);
    halt();
  endtask

  // R5 R6 R7 R12: 64 KiB wrap on region and pointer, write direction, stalls
  task automatic t_wrap();
    put_desc(32'h0002_FFF8, 32'h0001_FFFC, 16'h0006, 1'b0);
    put_desc(32'h0002_0000, 32'h0003_0000, 16'h0002, 1'b1);
    clear_logs();
    stall = 1'b1;
    go(32'h0002_FFF8, 1'b1);
    @(negedge clk);
    wait_idle("R12 stalled walk", 400);
    stall = 1'b0;
    exp_fetch(32'h0002_FFF8);
    exp_words(32'h0001_FFFC, 3, 1'b1);
    exp_fetch(32'h0002_0000);
    exp_words(32'h0003_0000, 1, 1'b1);
    check_seq("R5 R6 R7 R12 wrap sequence");
    halt();
  endtask

  // R11: no word requests while disk side has nothing
  task automatic t_avail();
    put_desc(32'h0000_2000, 32'h000A_0000, 16'h0004, 1'b1);
    clear_logs();
    xfer_avail_i = 1'b0;
    go(32'h0000_2000, 1'b0);
    repeat (30) @(negedge clk);
    check("R11 only fetches", 32'(log_addr.size()), 32'h2);
    check("R11 still active", 32'(active_o), 32'h1);
    xfer_avail_i = 1'b1;
    wait_idle("R11 resume", 100);
    exp_fetch(32'h0000_2000);
    exp_words(32'h000A_0000, 2, 1'b0);
    check_seq("R11 sequence");
    halt();
  endtask

  // R9: stop mid-walk, then restart from the first entry
  task automatic t_abort();
    int n;
    int k = 0;
    put_desc(32'h0000_3000, 32'h0006_0000, 16'h0008, 1'b1);
    clear_logs();
    go(32'h0000_3000, 1'b0);
    while (log_addr.size() < 3 && k < 100) begin
      @(negedge clk);
      k++;
    end
    start_i = 1'b0;
    @(negedge clk);
    check("R9 inactive after stop", 32'(active_o), 32'h0);
    @(negedge clk);
    n = log_addr.size();
    repeat (20) @(negedge clk);
    check("R9 no requests after stop", 32'(log_addr.size()), 32'(n));
    clear_logs();
    go(32'h0000_3000, 1'b0);
    @(negedge clk);
    wait_idle("R9 restart", 200);
    exp_fetch(32'h0000_3000);
    exp_words(32'h0006_0000, 4, 1'b0);
    check_seq("R9 restart from first entry");
    halt();
  endtask

  // R10: error response ends the walk with a single pulse
  task automatic t_error();
    put_desc(32'h0000_5000, 32'h0007_0000, 16'h0008, 1'b1);
    clear_logs();
    err_cnt  = 0;
    err_en   = 1'b1;
    err_addr = 32'h0007_0002;
    go(32'h0000_5000, 1'b1);
    @(negedge clk);
    wait_idle("R10 error stop", 200);
    repeat (10) @(negedge clk);
    check("R10 one err cycle", 32'(err_cnt), 32'h1);
    exp_fetch(32'h0000_5000);
    exp_words(32'h0007_0000, 2, 1'b1);
    check_seq("R10 no request after error");
    check("R10 stays idle", 32'(active_o), 32'h0);
    err_en = 1'b0;
    halt();
  endtask

  // R4: zero count field is a full 64 KiB region
  task automatic t_full();
    put_desc(32'h0000_4000, 32'h0005_0000, 16'h0000, 1'b1);
    clear_logs();
    go(32'h0000_4000, 1'b0);
    @(negedge clk);
    wait_idle("R4 full region", 80000);
    exp_fetch(32'h0000_4000);
    exp_words(32'h0005_0000, 32768, 1'b0);
    check_seq("R4 65536 byte region");
    check("R4 last word addr", log_addr[log_addr.size() - 1], 32'h0005_FFFE);
    halt();
  endtask

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_no_level();
    t_wrap();
    t_avail();
    t_abort();
    t_error();
    t_full();
    summary();
    $finish;
  end
endmodule